// File: doc/BRIEF.md
# Cascadable Token-Shift Pixel Loader

This block fills the 192 x 6-bit intensity store of a display column driver. On every clock edge of a load it takes three 6-bit words, one per color bank, and writes them into one column triplet. The triplet is picked by a one-hot token that walks through a chain of 64 stages. Stage 0 sits at the left end of the chain and stage 63 at the right end. Stage s owns columns 3s, 3s+1 and 3s+2 (0-based), which belong to banks A, B and C. The banks are therefore interleaved across the column range.

A direction input selects whether the token walks left to right or right to left. The block has a token input and a token output at each end, so several drivers can be chained. The upstream driver's outgoing token starts this block's load. When this block writes its final stage, its own outgoing token hands the load on to the next driver. All token pins are active low. Reset is synchronous and active high. A combinational read port returns any stored column.

Top module: `pixel_token_loader`

## Requirements
- R1: During a load, every clock edge writes bus_a to column 3s, bus_b to column 3s+1 and bus_c to column 3s+2, where s is the stage the token selects on that edge.
- R2: rd_data returns the stored 6-bit value of column rd_col (0..191) combinationally, and returns 0 for rd_col of 192 or more.
- R3: At most one stage is selected at any time, and a complete load writes each of the 64 stages exactly once.
- R4: With dir_right = 1, the load writes stages 0, 1, ..., 63 on 64 consecutive edges. The token enters on left_tok_in_n and leaves on right_tok_out_n.
- R5: With dir_right = 0, the load writes stages 63, 62, ..., 0 on 64 consecutive edges. The token enters on right_tok_in_n and leaves on left_tok_out_n.
- R6: A load starts on the edge where the block is idle and the entry-side token input is low. The data on the buses at that same edge goes into the first stage, and busy is 1 from the next cycle on. A low level on the other side's token input starts nothing.
- R7: After the edge that writes the last stage, the exit-side token output is low for exactly one clock, and busy returns to 0 at the same time.
- R8: The token output on the entry side stays high throughout. The two token outputs are never low together.
- R9: While idle, the data buses have no effect on stored values.
- R10: A token input pulse that arrives while a load is running is ignored. The running load keeps its order and its end time.
- R11: Synchronous reset clears the token chain, stops a running load, clears the store to 0 and drives both token outputs high.
- R12: The direction is captured when a load starts. Changing dir_right during a load changes neither its order nor its exit pin.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shift clock |
| rst | input | 1 | Synchronous reset, active high |
| dir_right | input | 1 | 1: token walks stage 0 to 63; 0: stage 63 to 0 |
| left_tok_in_n | input | 1 | Incoming token at the left end, active low |
| right_tok_in_n | input | 1 | Incoming token at the right end, active low |
| left_tok_out_n | output | 1 | Outgoing token at the left end, active low |
| right_tok_out_n | output | 1 | Outgoing token at the right end, active low |
| bus_a | input | 6 | Bank A word |
| bus_b | input | 6 | Bank B word |
| bus_c | input | 6 | Bank C word |
| rd_col | input | 8 | Column index for readback |
| rd_data | output | 6 | Stored value of column rd_col |
| busy | output | 1 | High while a load is in progress |

## Verification
Full loads run in both directions with bus values that depend on the step index and the bank. A wrong order, a reversed direction or a swapped bank therefore lands a value in a column where the readback does not match. The position of the exit token pulse, and the pin it appears on, separates correct end timing and pin selection from an off-by-one chain or a pulse on the wrong side. Further patterns cover data that toggles while idle, a token on the wrong-side input, a second token in mid-load, a flip of the direction in mid-load, and a reset in mid-load. Each of these isolates one ignore or capture rule.

// File: rtl/ptl_pkg.sv
package ptl_pkg;

  // Column number for a stage and a bank (bank 0 = A, 1 = B, 2 = C)
  function automatic int col_index(input int stage, input int bank, input int banks);
    return stage * banks + bank;
  endfunction

  // Stage that is written first for a given direction
  function automatic int entry_stage(input logic to_right, input int stages);
    return to_right ? 0 : stages - 1;
  endfunction

  // Stage that is written last for a given direction
  function automatic int exit_stage(input logic to_right, input int stages);
    return to_right ? stages - 1 : 0;
  endfunction

endpackage

// File: rtl/ptl_token_shifter.sv
module ptl_token_shifter #(
  parameter int STAGES = 64
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              dir_live,
  output logic [STAGES-1:0] wr_sel,
  output logic              busy,
  output logic              last_wr,
  output logic              dir_run
);
  import ptl_pkg::*;

  localparam int FIRST_R = entry_stage(1'b1, STAGES);
  localparam int FIRST_L = entry_stage(1'b0, STAGES);
  localparam int LAST_R  = exit_stage(1'b1, STAGES);
  localparam int LAST_L  = exit_stage(1'b0, STAGES);

  logic [STAGES-1:0] sel_q;
  logic [STAGES-1:0] sel_d;
  logic              dir_q;
  logic              start_ok;

  assign busy     = |sel_q;
  assign start_ok = start && !busy;
  assign dir_run  = busy ? dir_q : dir_live;

  always_comb begin
    wr_sel = sel_q;
    if (!busy) begin
      wr_sel = '0;
      if (start) begin
        if (dir_live) wr_sel[FIRST_R] = 1'b1;
        else          wr_sel[FIRST_L] = 1'b1;
      end
    end
  end

  assign last_wr = dir_run ? wr_sel[LAST_R] : wr_sel[LAST_L];

  // Next-token network: each stage takes from its left or right neighbour
  for (genvar i = 0; i < STAGES; i++) begin : g_hop
    if (i == 0) begin : g_lo
      assign sel_d[i] = dir_run ? 1'b0 : wr_sel[i+1];
    end else if (i == STAGES - 1) begin : g_hi
      assign sel_d[i] = dir_run ? wr_sel[i-1] : 1'b0;
    end else begin : g_mid
      assign sel_d[i] = dir_run ? wr_sel[i-1] : wr_sel[i+1];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sel_q <= '0;
      dir_q <= 1'b1;
    end else begin
      sel_q <= sel_d;
      if (start_ok) dir_q <= dir_live;
    end
  end

  // R3: never more than one live stage
  assert_single_stage_R3: assert property (@(posedge clk) disable iff (rst)
    $onehot0(sel_q))
    else $error("token chain holds more than one stage");

  // R6: an accepted start leaves the chain busy
  assert_start_busy_R6: assert property (@(posedge clk) disable iff (rst)
    start_ok |=> busy)
    else $error("start did not launch the token");

  // R7: chain is empty after the last write
  assert_end_idle_R7: assert property (@(posedge clk) disable iff (rst)
    last_wr |=> !busy)
    else $error("token still live after last stage");

  // R12: direction is held for the whole load
  assert_dir_held_R12: assert property (@(posedge clk) disable iff (rst)
    (busy && !last_wr) |=> (dir_run == $past(dir_run)))
    else $error("direction changed during a load");

endmodule

// File: rtl/ptl_cascade_port.sv
module ptl_cascade_port (
  input  logic clk,
  input  logic rst,
  input  logic dir_live,
  input  logic busy,
  input  logic last_wr,
  input  logic dir_run,
  input  logic left_in_n,
  input  logic right_in_n,
  output logic start,
  output logic left_out_n,
  output logic right_out_n
);
  logic pulse_q;
  logic side_q;

  // Entry pin follows the live direction while idle
  assign start = !busy && (dir_live ? !left_in_n : !right_in_n);

  always_ff @(posedge clk) begin
    if (rst) begin
      pulse_q <= 1'b0;
      side_q  <= 1'b1;
    end else begin
      pulse_q <= last_wr;
      if (last_wr) side_q <= dir_run;
    end
  end

  assign left_out_n  = !(pulse_q && !side_q);
  assign right_out_n = !(pulse_q && side_q);

  // R8: outputs never low together
  assert_outs_exclusive_R8: assert property (@(posedge clk) disable iff (rst)
    !(!left_out_n && !right_out_n))
    else $error("both token outputs asserted");

  // R7: outgoing token lasts exactly one clock
  assert_left_pulse_R7: assert property (@(posedge clk) disable iff (rst)
    !left_out_n |=> left_out_n)
    else $error("left token output held more than one clock");
  assert_right_pulse_R7: assert property (@(posedge clk) disable iff (rst)
    !right_out_n |=> right_out_n)
    else $error("right token output held more than one clock");
  assert_pulse_follows_R7: assert property (@(posedge clk) disable iff (rst)
    last_wr |=> (!left_out_n || !right_out_n))
    else $error("no outgoing token after last stage");

endmodule

// File: rtl/ptl_pixel_store.sv
module ptl_pixel_store #(
  parameter int STAGES = 64,
  parameter int BANKS  = 3,
  parameter int DW     = 6,
  localparam int COLS  = STAGES * BANKS,
  localparam int COLW  = $clog2(COLS)
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic [STAGES-1:0]          wr_sel,
  input  logic [BANKS-1:0][DW-1:0]   wr_data,
  input  logic [COLW-1:0]            rd_col,
  output logic [DW-1:0]              rd_data
);
  import ptl_pkg::*;

  logic [COLS-1:0][DW-1:0] mem_q;
  logic                    any_wr;

  assign any_wr = |wr_sel;

  always_ff @(posedge clk) begin
    if (rst) begin
      mem_q <= '0;
    end else begin
      for (int s = 0; s < STAGES; s++) begin
        if (wr_sel[s]) begin
          for (int b = 0; b < BANKS; b++) begin
            mem_q[col_index(s, b, BANKS)] <= wr_data[b];
          end
        end
      end
    end
  end

  assign rd_data = (int'(rd_col) < COLS) ? mem_q[rd_col] : '0;

  // R9: without a selected stage, stored contents stay put
  assert_idle_hold_R9: assert property (@(posedge clk) disable iff (rst)
    !any_wr |=> (!$stable(rd_col) || $stable(rd_data)))
    else $error("store changed without a write");

endmodule

// File: rtl/pixel_token_loader.sv
module pixel_token_loader #(
  parameter int STAGES = 64,
  parameter int DW     = 6,
  localparam int BANKS = 3,
  localparam int COLS  = STAGES * BANKS,
  localparam int COLW  = $clog2(COLS)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            dir_right,
  input  logic            left_tok_in_n,
  input  logic            right_tok_in_n,
  output logic            left_tok_out_n,
  output logic            right_tok_out_n,
  input  logic [DW-1:0]   bus_a,
  input  logic [DW-1:0]   bus_b,
  input  logic [DW-1:0]   bus_c,
  input  logic [COLW-1:0] rd_col,
  output logic [DW-1:0]   rd_data,
  output logic            busy
);
  logic [STAGES-1:0]        wr_sel;
  logic                     start;
  logic                     last_wr;
  logic                     dir_run;
  logic [BANKS-1:0][DW-1:0] wr_data;

  assign wr_data = {bus_c, bus_b, bus_a};

  ptl_cascade_port u_port (
    .clk        (clk),
    .rst        (rst),
    .dir_live   (dir_right),
    .busy       (busy),
    .last_wr    (last_wr),
    .dir_run    (dir_run),
    .left_in_n  (left_tok_in_n),
    .right_in_n (right_tok_in_n),
    .start      (start),
    .left_out_n (left_tok_out_n),
    .right_out_n(right_tok_out_n)
  );

  ptl_token_shifter #(.STAGES(STAGES)) u_chain (
    .clk     (clk),
    .rst     (rst),
    .start   (start),
    .dir_live(dir_right),
    .wr_sel  (wr_sel),
    .busy    (busy),
    .last_wr (last_wr),
    .dir_run (dir_run)
  );

  ptl_pixel_store #(.STAGES(STAGES), .BANKS(BANKS), .DW(DW)) u_store (
    .clk    (clk),
    .rst    (rst),
    .wr_sel (wr_sel),
    .wr_data(wr_data),
    .rd_col (rd_col),
    .rd_data(rd_data)
  );

  // R11: right after reset both token outputs are high and nothing runs
  assert_reset_quiet_R11: assert property (@(posedge clk)
    $past(rst) |-> (left_tok_out_n && right_tok_out_n && !busy))
    else $error("state not cleared by reset");

endmodule

// File: tb/pixel_token_loader_bench.sv
module pixel_token_loader_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NST = 64;
  localparam int NCOL = 192;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic dir_right = 1'b1;
  logic left_tok_in_n = 1'b1;
  logic right_tok_in_n = 1'b1;
  logic left_tok_out_n, right_tok_out_n;
  logic [5:0] bus_a = '0, bus_b = '0, bus_c = '0;
  logic [7:0] rd_col = '0;
  logic [5:0] rd_data;
  logic busy;

  int checks = 0;
  int failures = 0;
  logic [5:0] expv [NCOL];

  // entry: {dir, expected exit side (1 = right), seed}
  localparam logic [7:0] VEC [0:3] = '{
    {1'b1, 1'b1, 6'd5},
    {1'b0, 1'b0, 6'd17},
    {1'b1, 1'b1, 6'd40},
    {1'b0, 1'b0, 6'd63}
  };

  pixel_token_loader u_pixel_token_loader (
    .clk(clk), .rst(rst), .dir_right(dir_right),
    .left_tok_in_n(left_tok_in_n), .right_tok_in_n(right_tok_in_n),
    .left_tok_out_n(left_tok_out_n), .right_tok_out_n(right_tok_out_n),
    .bus_a(bus_a), .bus_b(bus_b), .bus_c(bus_c),
    .rd_col(rd_col), .rd_data(rd_data), .busy(busy)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [5:0] pix(input int seed, input int step, input int bank);
    return 6'((seed * 5 + step * 11 + bank * 23 + (step >> 3)) & 63);
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic readback(input string tag);
    int bad = 0;
    int first_bad = -1;
    int act_bad = 0;
    for (int c = 0; c < NCOL; c++) begin
      rd_col = 8'(c);
      #1;
      if (rd_data !== expv[c]) begin
        if (first_bad < 0) begin first_bad = c; act_bad = rd_data; end
        bad++;
      end
    end
    chk(bad == 0, tag, act_bad, (first_bad < 0) ? 0 : expv[first_bad]);
    rd_col = 8'd200;
    #1;
    chk(rd_data == 6'd0, "R2 out-of-range column", rd_data, 0);
  endtask

  // Full load; mid_tok injects a second token at step 20, flip changes dir at step 30
  task automatic load_frame(input logic dir, input logic exp_side, input int seed,
                            input bit mid_tok, input bit flip, input string tag);
    int stg;
    int early_pulse = 0;
    dir_right = dir;
    for (int k = 0; k < NST; k++) begin
      bus_a = pix(seed, k, 0);
      bus_b = pix(seed, k, 1);
      bus_c = pix(seed, k, 2);
      if (k == 0 || (mid_tok && k == 20)) begin
        if (dir) left_tok_in_n = 1'b0; else right_tok_in_n = 1'b0;
      end else begin
        left_tok_in_n = 1'b1;
        right_tok_in_n = 1'b1;
      end
      if (flip && k == 30) dir_right = ~dir;
      if (!left_tok_out_n || !right_tok_out_n) early_pulse++;
      stg = dir ? k : NST - 1 - k;
      for (int b = 0; b < 3; b++) expv[3*stg + b] = pix(seed, k, b);
      tick();
      if (k == 0) chk(busy == 1'b1, {tag, " R6 busy after start"}, busy, 1);
    end
    left_tok_in_n = 1'b1;
    right_tok_in_n = 1'b1;
    chk(early_pulse == 0, {tag, " R8 no token out during load"}, early_pulse, 0);
    // one cycle after the last-stage edge
    if (exp_side) begin
      chk(right_tok_out_n == 1'b0, {tag, " R7/R4 exit on right"}, right_tok_out_n, 0);
      chk(left_tok_out_n == 1'b1, {tag, " R8 left stays high"}, left_tok_out_n, 1);
    end else begin
      chk(left_tok_out_n == 1'b0, {tag, " R7/R5 exit on left"}, left_tok_out_n, 0);
      chk(right_tok_out_n == 1'b1, {tag, " R8 right stays high"}, right_tok_out_n, 1);
    end
    chk(busy == 1'b0, {tag, " R7 idle at end"}, busy, 0);
    tick();
    chk(left_tok_out_n && right_tok_out_n, {tag, " R7 single-clock pulse"},
        {left_tok_out_n, right_tok_out_n}, 3);
    dir_right = dir;
    readback({tag, " R1/R2/R3 store contents"});
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    for (int c = 0; c < NCOL; c++) expv[c] = 6'd0;
    repeat (3) tick();
    // R11: reset state
    chk(left_tok_out_n && right_tok_out_n, "R11 outputs high in reset",
        {left_tok_out_n, right_tok_out_n}, 3);
    chk(busy == 1'b0, "R11 idle in reset", busy, 0);
    rst = 1'b0;
    tick();
    readback("R11 store cleared");

    // Vector table: full loads in both directions
    for (int v = 0; v < 4; v++) begin
      load_frame(VEC[v][7], VEC[v][6], int'(VEC[v][5:0]), 1'b0, 1'b0,
                 VEC[v][7] ? "R4 vec" : "R5 vec");
    end

    // R9: buses toggle while idle, store unchanged
    for (int k = 0; k < 12; k++) begin
      bus_a = 6'(k * 7 + 1); bus_b = 6'(k * 13 + 2); bus_c = 6'(k * 29 + 3);
      tick();
    end
    readback("R9 idle bus activity");

    // R6: token on the wrong-side input starts nothing
    dir_right = 1'b1;
    right_tok_in_n = 1'b0;
    bus_a = 6'h2a; bus_b = 6'h15; bus_c = 6'h3f;
    tick();
    right_tok_in_n = 1'b1;
    chk(busy == 1'b0, "R6 wrong-side token ignored", busy, 0);
    repeat (NST + 2) begin
      if (!left_tok_out_n || !right_tok_out_n) chk(1'b0, "R6 spurious token out", 0, 1);
      tick();
    end
    readback("R6 wrong-side token store");

    // R10: second token mid-load
    load_frame(1'b0, 1'b0, 33, 1'b1, 1'b0, "R10 mid token");
    // R12: direction flipped mid-load
    load_frame(1'b1, 1'b1, 9, 1'b0, 1'b1, "R12 dir flip");

    // R11: reset in the middle of a load
    dir_right = 1'b1;
    left_tok_in_n = 1'b0;
    tick();
    left_tok_in_n = 1'b1;
    repeat (10) tick();
    rst = 1'b1;
    tick();
    rst = 1'b0;
    chk(busy == 1'b0, "R11 load stopped by reset", busy, 0);
    begin
      int seen = 0;
      repeat (NST + 4) begin
        if (!left_tok_out_n || !right_tok_out_n) seen++;
        tick();
      end
      chk(seen == 0, "R11 no token out after reset", seen, 0);
    end
    for (int c = 0; c < NCOL; c++) expv[c] = 6'd0;
    readback("R11 store cleared mid-load");

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule